// File: doc/BRIEF.md
# Receive Message FIFO with Status Register

This block holds messages that a controller-area-network style receiver has already accepted through its filters, keeping up to three of them in arrival order. A one-cycle store pulse carries each new message word in. The oldest held message is always presented on the output mailbox, together with a flag that says whether the mailbox holds anything.

Software sees one 32-bit status word. It holds the pending count, a sticky full flag, a sticky overrun flag and a release request bit. Software writes a 1 to the release bit to retire the mailbox message and move to the next one. It writes 1s to the full or overrun flag to clear them. The release bit clears itself once the hardware has acted on it. A store that finds all three slots occupied is dropped and raises the overrun flag. A release that arrives in the same cycle as a store frees a slot first, so such a store is never dropped.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset the status word reads 0x00000000 and the mailbox-valid output is 0.
- R2: Each accepted store raises the pending count in status bits 1:0 by one, and the mailbox shows the oldest held message first.
- R3: Writing 1 to status bit 5 retires the mailbox message one cycle later: the count falls by one and the next older message appears in the mailbox.
- R4: A release request made while the count is 0 leaves the count at 0 and the mailbox-valid output at 0.
- R5: The release bit (bit 5) reads 1 in the cycle after software writes it, and reads 0 one cycle after that.
- R6: The full flag (bit 3) becomes 1 when a store brings the count to 3. It stays 1 until software writes 1 to bit 3.
- R7: The overrun flag (bit 4) becomes 1 when a store arrives while 3 messages are held and no release is being carried out. It stays 1 until software writes 1 to bit 4.
- R8: A store that arrives while the FIFO is full is discarded. The three held messages and their order do not change.
- R9: When a store and a release are carried out in the same cycle on a non-empty FIFO, the count stays the same, the new message goes in behind the others, and no overrun is flagged, even when the FIFO is full.
- R10: Status bit 2 and bits 31:6 always read 0. Writing 0 to bits 3, 4 or 5 leaves the full flag, the overrun flag and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| store_vld | input | 1 | One-cycle pulse that stores a filtered message |
| store_msg | input | MSG_W | Message word that goes with store_vld |
| csr_wr_en | input | 1 | Software write strobe for the status word |
| csr_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Status word: count [1:0], full [3], overrun [4], release [5] |
| mbox_vld | output | 1 | The mailbox holds a pending message |
| mbox_msg | output | MSG_W | Oldest pending message |

## Verification
The assertions check on every cycle that the count moves by exactly one on a lone store, and by zero on a combined store and release. They also check that the release bit lasts one cycle, that the flags stay set unless cleared by a write of 1, that a store into a full FIFO sets the overrun flag and leaves the mailbox alone, and that the reserved bits read zero. Only the bench scenarios can show that messages leave in arrival order, that a dropped message never shows up later, and that a message stored during a release in a full FIFO ends up behind the other held messages.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int CSR_W        = 32;
    localparam int STS_CNT_LSB  = 0;
    localparam int STS_FULL_BIT = 3;
    localparam int STS_OVR_BIT  = 4;
    localparam int STS_REL_BIT  = 5;
endpackage

// File: rtl/rxf_ring.sv
module rxf_ring #(
    parameter int DEPTH = 3,
    parameter int MSG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [MSG_W-1:0] wdata,
    output logic [MSG_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][MSG_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
    } ring_t;

    ring_t r_d, r_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d = r_q;
        if (push) begin
            r_d.mem[r_q.wr] = wdata;
            r_d.wr          = step(r_q.wr);
        end
        if (pop) begin
            r_d.rd = step(r_q.rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign head = r_q.mem[r_q.rd];
endmodule

// File: rtl/rxf_status.sv
module rxf_status
    import rxf_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_vld,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wdata,
    output logic             push,
    output logic             pop,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic             ovr,
    output logic             rel
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             full;
        logic             ovr;
        logic             rel;
    } sts_t;

    sts_t s_d, s_q;
    logic room;

    always_comb begin
        s_d  = s_q;
        pop  = s_q.rel && (s_q.cnt != '0);
        room = (s_q.cnt != CNT_MAX) || pop;
        push = store_vld && room;

        s_d.cnt  = s_q.cnt + CNT_W'(push) - CNT_W'(pop);
        s_d.full = (push && (s_d.cnt == CNT_MAX))
                 || (s_q.full && !(wr_en && wdata[STS_FULL_BIT]));
        s_d.ovr  = (store_vld && !room)
                 || (s_q.ovr && !(wr_en && wdata[STS_OVR_BIT]));
        // A pending request is consumed this cycle; a fresh write re-arms it.
        s_d.rel  = wr_en && wdata[STS_REL_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt  = s_q.cnt;
    assign full = s_q.full;
    assign ovr  = s_q.ovr;
    assign rel  = s_q.rel;
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int MSG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_vld,
    input  logic [MSG_W-1:0] store_msg,
    input  logic             csr_wr_en,
    input  logic [31:0]      csr_wdata,
    output logic [31:0]      csr_rdata,
    output logic             mbox_vld,
    output logic [MSG_W-1:0] mbox_msg
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push, pop, full, ovr, rel;
    logic [CNT_W-1:0] cnt;

    rxf_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_vld (store_vld),
        .wr_en     (csr_wr_en),
        .wdata     (csr_wdata),
        .push      (push),
        .pop       (pop),
        .cnt       (cnt),
        .full      (full),
        .ovr       (ovr),
        .rel       (rel)
    );

    rxf_ring #(.DEPTH(DEPTH), .MSG_W(MSG_W)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (store_msg),
        .head  (mbox_msg)
    );

    always_comb begin
        csr_rdata                                = '0;
        csr_rdata[STS_CNT_LSB +: CNT_W]          = cnt;
        csr_rdata[STS_FULL_BIT]                  = full;
        csr_rdata[STS_OVR_BIT]                   = ovr;
        csr_rdata[STS_REL_BIT]                   = rel;
    end

    assign mbox_vld = (cnt != '0);
endmodule

// File: rtl/rx_msg_fifo_chk.sv
module rx_msg_fifo_chk #(
    parameter int DEPTH = 3,
    parameter int MSG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             store_vld,
    input logic             csr_wr_en,
    input logic [31:0]      csr_wdata,
    input logic [31:0]      csr_rdata,
    input logic             mbox_vld,
    input logic [MSG_W-1:0] mbox_msg
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt;
    logic full, ovr, rel;
    assign cnt  = csr_rdata[CNT_W-1:0];
    assign full = csr_rdata[3];
    assign ovr  = csr_rdata[4];
    assign rel  = csr_rdata[5];

    // R2: a lone store into a non-full FIFO adds exactly one
    p_store_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (store_vld && !rel && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

    // R3: a carried-out release without a store removes exactly one
    p_release_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !store_vld && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R4: release on empty changes nothing
    p_empty_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !store_vld && cnt == '0) |=> (cnt == '0 && !mbox_vld));

    // R5: release bit lasts one cycle unless re-written
    p_rel_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !(csr_wr_en && csr_wdata[5])) |=> !rel);

    // R6: full flag sticky until write-one
    p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(csr_wr_en && csr_wdata[3])) |=> full);

    // R7: overrun flag set on store into full FIFO, sticky until write-one
    p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_vld && !rel && cnt == CNT_MAX) |=> ovr);
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(csr_wr_en && csr_wdata[4])) |=> ovr);

    // R8: dropped store leaves the mailbox and count untouched
    p_drop_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (store_vld && !rel && cnt == CNT_MAX) |=> ($stable(mbox_msg) && cnt == CNT_MAX));

    // R9: combined store and release keeps the count and raises no overrun
    p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (store_vld && rel && cnt != '0 && !ovr) |=> (cnt == $past(cnt) && !ovr));

    // R10: reserved bits read zero
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[2] == 1'b0 && csr_rdata[31:6] == '0));
endmodule

bind rx_msg_fifo rx_msg_fifo_chk #(.DEPTH(DEPTH), .MSG_W(MSG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_vld (store_vld),
    .csr_wr_en (csr_wr_en),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .mbox_vld  (mbox_vld),
    .mbox_msg  (mbox_msg)
);

// File: tb/rx_msg_fifo_test.sv
module rx_msg_fifo_test;
    localparam int MSG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             store_vld = 1'b0;
    logic [MSG_W-1:0] store_msg = '0;
    logic             csr_wr_en = 1'b0;
    logic [31:0]      csr_wdata = '0;
    logic [31:0]      csr_rdata;
    logic             mbox_vld;
    logic [MSG_W-1:0] mbox_msg;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [MSG_W-1:0] exp_q[$];
    bit m_full = 0;
    bit m_ovr  = 0;

    always #2 clk = ~clk;

    rx_msg_fifo uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_vld (store_vld),
        .store_msg (store_msg),
        .csr_wr_en (csr_wr_en),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .mbox_vld  (mbox_vld),
        .mbox_msg  (mbox_msg)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compares the port view with the scoreboard queue.
    task automatic compare(input string tag);
        check(tag, "count", {30'b0, csr_rdata[1:0]}, 32'(exp_q.size()));
        check(tag, "mbox_vld", {31'b0, mbox_vld}, {31'b0, exp_q.size() != 0});
        if (exp_q.size() != 0) check(tag, "mbox_msg", mbox_msg, exp_q[0]);
        check(tag, "full", {31'b0, csr_rdata[3]}, {31'b0, m_full});
        check(tag, "overrun", {31'b0, csr_rdata[4]}, {31'b0, m_ovr});
        check(tag, "reserved", {csr_rdata[31:6], 3'b0, csr_rdata[2], 2'b0}, 32'h0);
    endtask

    // Driver: store one message and record what the FIFO should hold.
    task automatic do_store(input logic [MSG_W-1:0] m);
        store_vld = 1'b1;
        store_msg = m;
        tick();
        store_vld = 1'b0;
        if (exp_q.size() < 3) begin
            exp_q.push_back(m);
            if (exp_q.size() == 3) m_full = 1;
        end else begin
            m_ovr = 1;
        end
    endtask

    task automatic do_write(input logic [31:0] w);
        csr_wr_en = 1'b1;
        csr_wdata = w;
        tick();
        csr_wr_en = 1'b0;
        csr_wdata = '0;
        if (w[3]) m_full = 0;
        if (w[4]) m_ovr  = 0;
        if (w[5]) begin
            check("R5", "release bit after write", {31'b0, csr_rdata[5]}, 32'h1);
            check("R5", "count held during request", {30'b0, csr_rdata[1:0]}, 32'(exp_q.size()));
        end
    endtask

    task automatic do_release(input string tag);
        do_write(32'h20);
        tick();
        check("R5", "release bit self-clears", {31'b0, csr_rdata[5]}, 32'h0);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        compare(tag);
    endtask

    // Release request then a store in the cycle the release is carried out.
    task automatic release_with_store(input logic [MSG_W-1:0] m);
        do_write(32'h20);
        store_vld = 1'b1;
        store_msg = m;
        tick();
        store_vld = 1'b0;
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        exp_q.push_back(m);
        if (exp_q.size() == 3) m_full = 1;
        compare("R9");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        compare("R1");
        check("R1", "status word", csr_rdata, 32'h0);
        rst_n = 1'b1;
        tick();
        compare("R1");

        // release on empty
        do_release("R4");
        check("R4", "mbox_vld after empty release", {31'b0, mbox_vld}, 32'h0);

        // fill in order
        do_store(32'hA000_0001);
        compare("R2");
        do_store(32'hB000_0002);
        compare("R2");
        do_store(32'hC000_0003);
        compare("R6");
        check("R6", "full flag", {31'b0, csr_rdata[3]}, 32'h1);

        // store into full FIFO is dropped
        do_store(32'hD000_0004);
        compare("R7");
        check("R8", "mailbox unchanged", mbox_msg, 32'hA000_0001);

        // zero writes and reserved writes change nothing
        do_write(32'h0);
        compare("R10");
        do_write(32'hFFFF_FFC4);
        compare("R10");

        // write-one clears
        do_write(32'h08);
        compare("R6");
        do_store(32'hD000_0005);
        compare("R7");
        do_write(32'h10);
        compare("R7");

        // full FIFO: store alongside release is accepted, no overrun
        release_with_store(32'hE000_0006);
        check("R9", "no overrun", {31'b0, csr_rdata[4]}, 32'h0);

        // drain: order must be B, C, E with dropped D never appearing
        do_release("R3");
        check("R8", "second message", mbox_msg, 32'hC000_0003);
        do_release("R3");
        check("R9", "stored-with-release message last", mbox_msg, 32'hE000_0006);
        do_release("R3");
        do_release("R4");

        // non-full combined store and release
        do_write(32'h08);
        compare("R6");
        do_store(32'hF000_0007);
        compare("R2");
        release_with_store(32'h1234_5678);
        check("R9", "new head", mbox_msg, 32'h1234_5678);
        do_release("R3");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule